// File: doc/BRIEF.md
# Lease Countdown Timer with Shift-Register Prescaler

This block tracks how much of an address lease is left, in whole seconds, on a 100 MHz system clock. A lease duration in seconds is loaded with a one-cycle pulse. The block counts it down once per second and raises a renewal warning at the halfway point. When the count reaches zero it flags expiry and holds there.

The one-second time base does not use a wide binary divider. A maximal-length linear feedback shift register steps from a fixed nonzero seed on every clock. The block compares that register against one terminal constant. The terminal constant is the state the register reaches one period after the seed. It is derived at elaboration from the seed and the cycle count, using a GF(2) matrix power, so the build never steps the register a hundred million times. On a match, the block emits a one-cycle tick and reloads the seed.

The lease countdown itself is a narrow binary counter, sized for the one-day ceiling. All pins are plain control and status; the lease value travels with its load pulse and has no handshake.

Top module: `lease_timer`

## Requirements
- R1: After reset, and in the cycle after a clear, the remaining count reads 0 and both the renewal flag and the expiry flag read 0. No lease is held until the next load.
- R2: The seconds tick is high for exactly one cycle every TICK_CYCLES clocks. The first tick after a load or clear falls in the TICK_CYCLES-th cycle after that edge. The prescaler state is never all-zero.
- R3: A load pulse sets the remaining count to the lease value in the following cycle and restarts the prescaler from its seed, discarding any partial second.
- R4: A lease value above MAX_LEASE (86400 by default) is stored as MAX_LEASE; values at or below it are stored unchanged.
- R5: While a lease is held and the count is nonzero, each tick lowers the count by exactly one, visible in the cycle after the tick.
- R6: The renewal flag is high while a lease is held and the remaining count is at or below floor(loaded value / 2), where the loaded value is taken after clamping.
- R7: The expiry flag is high while a lease is held and the count is 0. Further ticks leave the count at 0.
- R8: When clear and load are high in the same cycle, clear takes effect and the load is ignored.
- R9: Loading a lease of 0 raises the expiry flag and the renewal flag in the next cycle.
- R10: The terminal compare value equals the seed stepped TICK_CYCLES−1 times, so the tick period depends only on the TICK_CYCLES and SEED parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lease_load | input | 1 | One-cycle pulse that loads lease_secs |
| lease_secs | input | 32 | Lease duration in seconds |
| lease_clear | input | 1 | Drops the held lease and restarts the prescaler |
| sec_tick | output | 1 | One-cycle pulse once per second |
| secs_left | output | 17 | Remaining lease seconds |
| renew_due | output | 1 | Remaining time at or below half of the loaded lease |
| lease_expired | output | 1 | Held lease has reached zero |

## Verification
The bench uses a short tick period and times every tick against a cycle count taken from the load edge. An early or late terminal constant therefore shows up as a tick one cycle off. Even and odd lease values place the halfway mark on and off an exact half, which separates a floor from a ceiling in the renewal compare. Values just above, at and far above the ceiling show whether clamping happens before storage. A reload in mid-second, a clear that coincides with a load, and a load of zero show whether a partial second leaks across a restart and which control wins.

// File: rtl/lease_timer_pkg.sv
package lease_timer_pkg;
  localparam int unsigned LEASE_IN_W     = 32;
  localparam int unsigned DEF_MAX_LEASE  = 86400;
  localparam int unsigned DEF_TICK_CYC   = 100_000_000;
  localparam int unsigned DEF_LFSR_W     = 27;
  // taps at stages 27, 5, 2, 1 give a maximal sequence for 27 bits
  localparam logic [DEF_LFSR_W-1:0] DEF_TAPS = 27'h400_0013;
  localparam logic [DEF_LFSR_W-1:0] DEF_SEED = 27'h000_0001;
endpackage

// File: rtl/lease_lfsr_tick.sv
module lease_lfsr_tick #(
  parameter int unsigned W          = 27,
  parameter int unsigned TICK_CYCLES = 100_000_000,
  parameter logic [W-1:0] TAPS      = '0,
  parameter logic [W-1:0] SEED      = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  typedef logic [W-1:0][W-1:0] gf2_mat_t;

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [W-1:0] mat_apply(input gf2_mat_t m, input logic [W-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int j = 0; j < int'(W); j++) if (v[j]) r = r ^ m[j];
    return r;
  endfunction

  // column view: result = a applied after b
  function automatic gf2_mat_t mat_compose(input gf2_mat_t a, input gf2_mat_t b);
    gf2_mat_t c;
    for (int i = 0; i < int'(W); i++) c[i] = mat_apply(a, b[i]);
    return c;
  endfunction

  function automatic logic [W-1:0] lfsr_jump(input logic [W-1:0] s, input int unsigned n);
    gf2_mat_t base, acc;
    int unsigned k;
    for (int j = 0; j < int'(W); j++) begin
      base[j] = lfsr_next({{(W-1){1'b0}}, 1'b1} << j);
      acc[j]  = {{(W-1){1'b0}}, 1'b1} << j;
    end
    k = n;
    for (int b = 0; b < 32; b++) begin
      if (k[0]) acc = mat_compose(base, acc);
      base = mat_compose(base, base);
      k = k >> 1;
    end
    return mat_apply(acc, s);
  endfunction

  localparam logic [W-1:0] TERMINAL = lfsr_jump(SEED, TICK_CYCLES - 1);

  logic [W-1:0] state_q;

  assign tick = (state_q == TERMINAL);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) state_q <= SEED;
    else                        state_q <= lfsr_next(state_q);
  end

  // R2: the shift register must never fall into the lock-up state
  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  // R3: a restart lands the prescaler on its seed
  a_r3_restart_seed: assert property (@(posedge clk) disable iff (rst)
    restart |=> state_q == SEED);
  // R2: a tick is a single-cycle pulse
  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/lease_sec_counter.sv
module lease_sec_counter
  import lease_timer_pkg::*;
#(
  parameter int unsigned MAX_LEASE = DEF_MAX_LEASE,
  localparam int unsigned CNT_W    = $clog2(MAX_LEASE + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  clear,
  input  logic [LEASE_IN_W-1:0] lease_in,
  input  logic                  tick,
  output logic [CNT_W-1:0]      remaining,
  output logic                  renew_due,
  output logic                  expired
);
  logic             armed_q;
  logic [CNT_W-1:0] count_q, half_q, clamped;

  assign clamped = (lease_in > LEASE_IN_W'(MAX_LEASE)) ? CNT_W'(MAX_LEASE)
                                                       : lease_in[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      armed_q <= 1'b0;
      count_q <= '0;
      half_q  <= '0;
    end else if (load) begin
      armed_q <= 1'b1;
      count_q <= clamped;
      half_q  <= clamped >> 1;
    end else if (tick && armed_q && count_q != '0) begin
      count_q <= count_q - CNT_W'(1);
    end
  end

  assign remaining = count_q;
  assign renew_due = armed_q && (count_q <= half_q);
  assign expired   = armed_q && (count_q == '0);

  // R4: stored count never exceeds the ceiling
  a_r4_clamp_ceiling: assert property (@(posedge clk) disable iff (rst)
    remaining <= CNT_W'(MAX_LEASE));
  // R5: one tick removes exactly one second
  a_r5_one_per_tick: assert property (@(posedge clk) disable iff (rst)
    (tick && armed_q && remaining != '0 && !load && !clear)
      |=> remaining == $past(remaining) - CNT_W'(1));
  // R7: expiry persists until a load or clear
  a_r7_expired_holds: assert property (@(posedge clk) disable iff (rst)
    (expired && !load && !clear) |=> expired && remaining == '0);
  // R8: clear beats load
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear |=> remaining == '0 && !expired && !renew_due);
endmodule

// File: rtl/lease_timer.sv
module lease_timer
  import lease_timer_pkg::*;
#(
  parameter int unsigned MAX_LEASE   = DEF_MAX_LEASE,
  parameter int unsigned TICK_CYCLES = DEF_TICK_CYC,
  parameter int unsigned LFSR_W      = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] TAPS  = DEF_TAPS,
  parameter logic [LFSR_W-1:0] SEED  = DEF_SEED,
  localparam int unsigned CNT_W      = $clog2(MAX_LEASE + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lease_load,
  input  logic [LEASE_IN_W-1:0] lease_secs,
  input  logic                  lease_clear,
  output logic                  sec_tick,
  output logic [CNT_W-1:0]      secs_left,
  output logic                  renew_due,
  output logic                  lease_expired
);
  logic restart;
  assign restart = lease_load | lease_clear;

  lease_lfsr_tick #(
    .W(LFSR_W), .TICK_CYCLES(TICK_CYCLES), .TAPS(TAPS), .SEED(SEED)
  ) u_prescale (
    .clk(clk), .rst(rst), .restart(restart), .tick(sec_tick)
  );

  lease_sec_counter #(.MAX_LEASE(MAX_LEASE)) u_count (
    .clk(clk), .rst(rst), .load(lease_load), .clear(lease_clear),
    .lease_in(lease_secs), .tick(sec_tick),
    .remaining(secs_left), .renew_due(renew_due), .expired(lease_expired)
  );
endmodule

// File: tb/tb_lease_timer.sv
`timescale 1ns/1ps
module tb_lease_timer;
  localparam int unsigned N = 20;
  logic clk = 0, rst = 1, lease_load = 0, lease_clear = 0;
  logic [31:0] lease_secs = 0;
  logic sec_tick, renew_due, lease_expired;
  logic [16:0] secs_left;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  lease_timer #(.TICK_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .lease_load(lease_load), .lease_secs(lease_secs),
    .lease_clear(lease_clear), .sec_tick(sec_tick), .secs_left(secs_left),
    .renew_due(renew_due), .lease_expired(lease_expired));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int rem, input bit rn, input bit ex);
    check(secs_left == 17'(rem), {req, " secs_left"}, secs_left, rem);
    check(renew_due == rn, {req, " renew_due"}, renew_due, rn);
    check(lease_expired == ex, {req, " lease_expired"}, lease_expired, ex);
  endtask

  // ends at the first negedge after the load edge (cycle index 1)
  task automatic do_load(input int v);
    @(negedge clk); lease_secs = 32'(v); lease_load = 1;
    @(negedge clk); lease_load = 0;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 0, 0, 0);
  endtask

  task automatic t_tick_period;
    int bad = 0, first = -1;
    do_load(5);
    for (int j = 1; j <= 2 * N + 1; j++) begin
      if (sec_tick !== ((j == N) || (j == 2 * N))) bad++;
      if (sec_tick && first < 0) first = j;
      if (j != 2 * N + 1) @(negedge clk);
    end
    check(bad == 0, "R2 tick pattern", bad, 0);
    check(first == int'(N), "R10 first tick cycle", first, N);
  endtask

  task automatic t_countdown_even;
    do_load(4);
    chk_state("R3 load", 4, 0, 0);
    wait_n(N - 1);
    check(secs_left == 4, "R5 before tick", secs_left, 4);
    wait_n(1);
    check(secs_left == 3, "R5 after tick", secs_left, 3);
    wait_n(N - 1);
    chk_state("R6 above half", 3, 0, 0);
    wait_n(1);
    chk_state("R6 at half", 2, 1, 0);
    wait_n(2 * N);
    chk_state("R7 expired", 0, 1, 1);
    wait_n(3 * N);
    chk_state("R7 holds zero", 0, 1, 1);
  endtask

  task automatic t_odd_half;
    do_load(5);
    wait_n(2 * N);
    chk_state("R6 odd 3", 3, 0, 0);
    wait_n(N);
    chk_state("R6 odd 2", 2, 1, 0);
  endtask

  task automatic t_clamp;
    do_load(1_000_000);
    check(secs_left == 86400, "R4 far above", secs_left, 86400);
    do_load(86401);
    check(secs_left == 86400, "R4 just above", secs_left, 86400);
    do_load(86400);
    check(secs_left == 86400, "R4 at ceiling", secs_left, 86400);
    do_load(86399);
    check(secs_left == 86399, "R4 below", secs_left, 86399);
  endtask

  task automatic t_reload_mid;
    do_load(9);
    wait_n(7);
    do_load(3);
    wait_n(N - 1);
    check(secs_left == 3, "R3 no partial second", secs_left, 3);
    wait_n(1);
    check(secs_left == 2, "R3 first tick after reload", secs_left, 2);
  endtask

  task automatic t_clear;
    do_load(6);
    wait_n(N + 3);
    @(negedge clk); lease_clear = 1;
    @(negedge clk); lease_clear = 0;
    chk_state("R1 after clear", 0, 0, 0);
    wait_n(3 * N);
    chk_state("R1 idle stays", 0, 0, 0);
    @(negedge clk); lease_clear = 1; lease_load = 1; lease_secs = 7;
    @(negedge clk); lease_clear = 0; lease_load = 0;
    chk_state("R8 clear over load", 0, 0, 0);
  endtask

  task automatic t_zero;
    do_load(0);
    chk_state("R9 zero lease", 0, 1, 1);
    wait_n(2 * N);
    chk_state("R9 zero stays", 0, 1, 1);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset;
    rst = 0;
    wait_n(1);
    t_reset;
    t_tick_period;
    t_countdown_even;
    t_odd_half;
    t_clamp;
    t_reload_mid;
    t_clear;
    t_zero;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule